// File: doc/BRIEF.md
# Cached Block-RAM Accumulator Array

This block keeps an array of counters in a synchronous block RAM and adds a caller-supplied value into one counter per clock cycle. It suits histogram building and keyed aggregation, where a stream of (index, value) pairs updates a table and the totals are read back afterwards. Each update is a read-modify-write. The RAM read takes several cycles, so an update can read a counter before an earlier update to the same counter has written its new total.

A short shift register holds the most recent sums, each tagged with its index. It covers those stale reads. When an update's index matches a tag, the newest matching cached sum replaces the RAM data. As a result, updates to one index can arrive on every cycle with no stall. A clear command walks the whole RAM writing zeros and empties the cache. A second read port returns a stored total a fixed number of cycles after it is asked for.

Top module: `cached_hist_acc`

## Requirements
- R1: After reset, `busy` and `rd_ack` are low.
- R2: A cycle with `clr_req` high starts a sweep. `busy` is high for exactly DEPTH cycles, starting the cycle after the request. Afterwards every entry reads back as zero, index 0 and index DEPTH-1 included.
- R3: An update with `upd_valid` high adds `upd_val` into the entry at `upd_idx`. No other entry changes.
- R4: Updates to the same index on consecutive cycles all accumulate, with no update lost.
- R5: Interleaved updates to different indices accumulate correctly when same-index repeats are spaced 1 to RD_LAT+1 cycles apart.
- R6: Accumulation wraps modulo 2^WIDTH.
- R7: `rd_ack` goes high exactly RD_LAT cycles after a cycle with `rd_req` high, and is low before that. In that cycle `rd_data` holds the RAM contents at the `rd_idx` that was given with the request.
- R8: `busy` goes high the cycle after an update is accepted. It falls RD_LAT+1 cycles after the last accepted update. A read issued once `busy` is low returns the final total.
- R9: Updates presented while a sweep runs, or in the same cycle as `clr_req`, are ignored.
- R10: Updates still in the pipeline when `clr_req` arrives are discarded, so the entry reads zero after the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_req | input | 1 | Start a zeroing sweep of RAM and cache |
| upd_valid | input | 1 | Update strobe |
| upd_idx | input | $clog2(DEPTH) | Entry to update |
| upd_val | input | WIDTH | Value to add |
| rd_req | input | 1 | Read-back strobe |
| rd_idx | input | $clog2(DEPTH) | Entry to read back |
| rd_ack | output | 1 | Read-back data valid |
| rd_data | output | WIDTH | Read-back value |
| busy | output | 1 | Sweep running or updates in flight |

## Verification
The hardest case to reach is a commit whose RAM read is stale because one or more same-index writes are still in flight, together with several cache tags that match and disagree. The newest of them must win. The stimulus gets there with runs of same-index updates on every cycle, with A-B-A and A-B-C-A interleavings that place the repeat at each distance inside the cache window, and with a long pseudo-random stream confined to four indices. Sweeps are checked with updates offered during the sweep and with updates caught mid-pipeline.

// File: rtl/hacc_pkg.sv
package hacc_pkg;
  typedef enum logic [0:0] {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/hacc_ram.sv
module hacc_ram #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 16,
  parameter int RD_LAT = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ua_en,
  input  logic [IDX_W-1:0] ua_addr,
  output logic [WIDTH-1:0] ua_data,
  input  logic             rb_en,
  input  logic [IDX_W-1:0] rb_addr,
  output logic [WIDTH-1:0] rb_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] ua_pipe_q [RD_LAT];
  logic [WIDTH-1:0] rb_pipe_q [RD_LAT];

  // read-first storage: a read on the write edge returns the older word
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (ua_en) ua_pipe_q[0] <= mem_q[ua_addr];
    if (rb_en) rb_pipe_q[0] <= mem_q[rb_addr];
    for (int k = 1; k < RD_LAT; k++) begin
      ua_pipe_q[k] <= ua_pipe_q[k-1];
      rb_pipe_q[k] <= rb_pipe_q[k-1];
    end
  end

  assign ua_data = ua_pipe_q[RD_LAT-1];
  assign rb_data = rb_pipe_q[RD_LAT-1];
endmodule

// File: rtl/hacc_fwd_cache.sv
module hacc_fwd_cache #(
  parameter int WIDTH   = 16,
  parameter int IDX_W   = 6,
  parameter int ENTRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic [WIDTH-1:0] push_val,
  input  logic [IDX_W-1:0] look_idx,
  output logic             hit,
  output logic [WIDTH-1:0] hit_val
);
  logic [IDX_W-1:0] tag_q [ENTRIES];
  logic [IDX_W-1:0] tag_d [ENTRIES];
  logic [WIDTH-1:0] val_q [ENTRIES];
  logic [WIDTH-1:0] val_d [ENTRIES];

  // slot ENTRIES-1 is the newest; a later match in the scan overrides older ones
  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (tag_q[i] == look_idx) begin
        hit     = 1'b1;
        hit_val = val_q[i];
      end
    end
  end

  always_comb begin
    tag_d = tag_q;
    val_d = val_q;
    if (clr) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_d[i] = '0;
        val_d[i] = '0;
      end
    end else if (push) begin
      for (int i = 0; i < ENTRIES-1; i++) begin
        tag_d[i] = tag_q[i+1];
        val_d[i] = val_q[i+1];
      end
      tag_d[ENTRIES-1] = push_idx;
      val_d[ENTRIES-1] = push_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        val_q[i] <= '0;
      end
    end else if (clr || push) begin
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end

  // after a clear every tag carries a zero value, so any hit returns zero
  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hit_val == '0));
endmodule

// File: rtl/hacc_clear_seq.sv
module hacc_clear_seq
  import hacc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             sweeping,
  output logic [IDX_W-1:0] addr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH-1);

  sweep_state_e     st_q, st_d;
  logic [IDX_W-1:0] addr_q, addr_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    unique case (st_q)
      SWP_IDLE: if (start) begin
        st_d   = SWP_RUN;
        addr_d = '0;
      end
      SWP_RUN: begin
        if (addr_q == LAST) st_d = SWP_IDLE;
        else addr_d = addr_q + 1'b1;
      end
      default: st_d = SWP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SWP_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  assign sweeping = (st_q == SWP_RUN);
  assign addr     = addr_q;

  p_sweep_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sweeping) |=> (sweeping && addr == '0));
  p_sweep_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && addr == LAST) |=> !sweeping);
endmodule

// File: rtl/cached_hist_acc.sv
module cached_hist_acc #(
  parameter int DEPTH       = 64,
  parameter int WIDTH       = 16,
  parameter int RD_LAT      = 2,
  parameter int CACHE_DEPTH = 2,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ENTRIES = CACHE_DEPTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_req,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WIDTH-1:0] upd_val,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_ack,
  output logic [WIDTH-1:0] rd_data,
  output logic             busy
);
  localparam int L = RD_LAT;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             sweeping;
  logic [IDX_W-1:0] swp_addr;
  logic             accept, commit;
  logic [L-1:0]     stg_vld_q, stg_vld_d;
  logic [IDX_W-1:0] stg_idx_q [L];
  logic [WIDTH-1:0] stg_val_q [L];
  logic [L-1:0]     rb_vld_q, rb_vld_d;
  logic [WIDTH-1:0] ua_data, cur_val, sum;
  logic             c_hit;
  logic [WIDTH-1:0] c_val;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [WIDTH-1:0] wr_data;

  hacc_clear_seq #(.DEPTH(DEPTH)) u_clr (
    .clk(clk), .rst_n(rst_sync_q), .start(clr_req),
    .sweeping(sweeping), .addr(swp_addr)
  );

  assign accept = upd_valid && !sweeping && !clr_req;
  assign commit = stg_vld_q[L-1] && !clr_req;

  // update pipeline control: a clear request flushes every stage
  always_comb begin
    stg_vld_d = {stg_vld_q[L-2:0], accept};
    if (clr_req) stg_vld_d = '0;
    rb_vld_d = {rb_vld_q[L-2:0], rd_req};
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      stg_vld_q <= '0;
      rb_vld_q  <= '0;
    end else begin
      stg_vld_q <= stg_vld_d;
      rb_vld_q  <= rb_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      stg_idx_q[0] <= upd_idx;
      stg_val_q[0] <= upd_val;
    end
    for (int k = 1; k < L; k++) begin
      if (stg_vld_q[k-1]) begin
        stg_idx_q[k] <= stg_idx_q[k-1];
        stg_val_q[k] <= stg_val_q[k-1];
      end
    end
  end

  hacc_fwd_cache #(.WIDTH(WIDTH), .IDX_W(IDX_W), .ENTRIES(ENTRIES)) u_cache (
    .clk(clk), .rst_n(rst_sync_q), .clr(clr_req),
    .push(commit), .push_idx(stg_idx_q[L-1]), .push_val(sum),
    .look_idx(stg_idx_q[L-1]), .hit(c_hit), .hit_val(c_val)
  );

  assign cur_val = c_hit ? c_val : ua_data;
  assign sum     = cur_val + stg_val_q[L-1];

  assign wr_en   = sweeping || commit;
  assign wr_addr = sweeping ? swp_addr : stg_idx_q[L-1];
  assign wr_data = sweeping ? '0 : sum;

  hacc_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RD_LAT(RD_LAT)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ua_en(accept), .ua_addr(upd_idx), .ua_data(ua_data),
    .rb_en(rd_req), .rb_addr(rd_idx), .rb_data(rd_data)
  );

  assign rd_ack = rb_vld_q[L-1];
  assign busy   = sweeping || (|stg_vld_q);

  p_no_commit_in_sweep_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(commit && sweeping));
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    accept |=> busy);
  p_fwd_hit_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (commit && $past(commit) && stg_idx_q[L-1] == $past(stg_idx_q[L-1])) |-> c_hit);
endmodule

// File: tb/cached_hist_acc_tb_top.sv
module cached_hist_acc_tb_top;
  localparam int DEPTH  = 64;
  localparam int WIDTH  = 16;
  localparam int RD_LAT = 2;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, clr_req, upd_valid, rd_req;
  logic [IDX_W-1:0] upd_idx, rd_idx;
  logic [WIDTH-1:0] upd_val;
  logic             rd_ack, busy;
  logic [WIDTH-1:0] rd_data;

  cached_hist_acc #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RD_LAT(RD_LAT), .CACHE_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .upd_valid(upd_valid),
    .upd_idx(upd_idx), .upd_val(upd_val), .rd_req(rd_req), .rd_idx(rd_idx),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [WIDTH-1:0] model [DEPTH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic upd(input int idx, input int val);
    upd_valid = 1'b1;
    upd_idx   = IDX_W'(idx);
    upd_val   = WIDTH'(val);
    if (!busy_sweep) model[idx] = model[idx] + WIDTH'(val);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  bit busy_sweep = 1'b0;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (busy && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic rd_chk(input int idx, input string req);
    rd_req = 1'b1;
    rd_idx = IDX_W'(idx);
    @(negedge clk);
    rd_req = 1'b0;
    idle(RD_LAT - 1);
    chk(rd_ack === 1'b1, req, int'(rd_ack), 1);
    chk(rd_data === model[idx], req, int'(rd_data), int'(model[idx]));
  endtask

  task automatic do_clear();
    int cnt = 0;
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    while (busy && cnt < 2 * DEPTH) begin
      @(negedge clk);
      cnt++;
    end
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    chk(cnt == DEPTH, "R2 sweep length", cnt, DEPTH);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(rd_ack === 1'b0, "R1 rd_ack", int'(rd_ack), 0);
  endtask

  task automatic t_clear_all();
    do_clear();
    for (int i = 0; i < DEPTH; i++) rd_chk(i, "R2 zero after sweep");
  endtask

  task automatic t_single();
    upd(DEPTH-1, 77);
    drain();
    rd_chk(DEPTH-1, "R3 single update top index");
    upd(0, 5);
    drain();
    rd_chk(0, "R3 single update index 0");
    rd_chk(1, "R3 neighbour untouched");
    rd_chk(DEPTH-2, "R3 neighbour untouched");
  endtask

  task automatic t_b2b();
    for (int v = 1; v <= 8; v++) upd(9, v);
    drain();
    rd_chk(9, "R4 back-to-back same index");
    rd_chk(10, "R4 neighbour untouched");
  endtask

  task automatic t_pattern();
    upd(20, 1); upd(21, 2); upd(20, 3); upd(21, 4);
    upd(22, 5); upd(23, 6); upd(24, 7); upd(22, 8);
    upd(25, 9); upd(26, 10); upd(25, 11); upd(27, 12); upd(25, 13);
    upd(28, 1); idle(1); upd(28, 2); idle(2); upd(28, 4); idle(3); upd(28, 8);
    drain();
    for (int i = 20; i <= 28; i++) rd_chk(i, "R5 interleaved spacing");
  endtask

  task automatic t_wrap();
    upd(30, 16'hFFF0); upd(30, 16'h0020); upd(30, 16'hFFFF);
    drain();
    rd_chk(30, "R6 modulo wrap");
  endtask

  task automatic t_rd_latency();
    rd_req = 1'b1;
    rd_idx = IDX_W'(9);
    @(negedge clk);
    rd_req = 1'b0;
    for (int k = 1; k < RD_LAT; k++) begin
      chk(rd_ack === 1'b0, "R7 ack not early", int'(rd_ack), 0);
      @(negedge clk);
    end
    chk(rd_ack === 1'b1, "R7 ack on time", int'(rd_ack), 1);
    chk(rd_data === model[9], "R7 data", int'(rd_data), int'(model[9]));
    @(negedge clk);
    chk(rd_ack === 1'b0, "R7 ack single cycle", int'(rd_ack), 0);
  endtask

  task automatic t_busy();
    chk(busy === 1'b0, "R8 idle before", int'(busy), 0);
    upd(40, 3);
    chk(busy === 1'b1, "R8 busy after accept", int'(busy), 1);
    idle(RD_LAT - 1);
    chk(busy === 1'b1, "R8 busy until commit", int'(busy), 1);
    idle(1);
    chk(busy === 1'b0, "R8 busy falls", int'(busy), 0);
    rd_chk(40, "R8 read after busy low");
  endtask

  task automatic t_ignore_in_sweep();
    upd(41, 6);
    drain();
    clr_req = 1'b1;
    upd_valid = 1'b1; upd_idx = IDX_W'(42); upd_val = WIDTH'(50);
    @(negedge clk);
    clr_req = 1'b0;
    busy_sweep = 1'b1;
    for (int k = 0; k < 10; k++) upd(41, 100 + k);
    busy_sweep = 1'b0;
    drain();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rd_chk(41, "R9 ignored during sweep");
    rd_chk(42, "R9 ignored with clear request");
  endtask

  task automatic t_flush();
    upd(43, 9); upd(43, 9);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    drain();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rd_chk(43, "R10 in-flight discarded");
  endtask

  task automatic t_stress();
    logic [15:0] lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[4] || lf[6]) upd(int'(lf[1:0]), int'(lf[15:8]));
      else idle(1);
    end
    drain();
    for (int i = 0; i < 4; i++) rd_chk(i, "R4 R5 random stream");
  endtask

  initial begin
    rst_n = 1'b0; clr_req = 1'b0; upd_valid = 1'b0; rd_req = 1'b0;
    upd_idx = '0; upd_val = '0; rd_idx = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_clear_all();
    t_single();
    t_b2b();
    t_pattern();
    t_wrap();
    t_rd_latency();
    t_busy();
    t_ignore_in_sweep();
    t_flush();
    do_clear();
    t_stress();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end
endmodule